// File: doc/BRIEF.md
# Interrupt-Capable GPIO Pin Bank

This block drives and senses a bank of up to 32 general-purpose pins and turns selected pins into interrupt sources. Software reaches it through a plain 32-bit register bus: a request carries a valid strobe, a write flag, a byte address and write data. A read returns its data one cycle later, flagged by a response strobe. The bus has no back-pressure. A request is accepted in every cycle that `req_valid` is high, and the response cannot be stalled.

Each pin has three possible roles: sensed input, driven output, or interrupt input. Incoming pin levels pass through a two-stage synchroniser before anything reads them. An interrupt pin can watch either a level or an edge. For each pin, software picks the active sense and may ask for both edges to count. Edge events stay latched until software writes a one to the matching clear bit. Level events follow the pin directly. The interrupt enables are set through one register and dropped through another, so software never needs a read-modify-write. A single interrupt line is the OR of every pin that is both pending and enabled.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every configuration register, the output data, the enables and the edge flags are 0. `pin_oe` is all 0 and `irq_out` is 0.
- R2: The registers sit at these word-aligned byte addresses: 0x00 role (1 = interrupt pin), 0x04 direction (1 = output), 0x08 output data, 0x0C input data, 0x10 pending, 0x14 clear, 0x18 enable/disable, 0x1C enable-set, 0x20 sense, 0x24 edge select, 0x28 filter control, 0x4C both-edge. A read returns its data with `rsp_valid` on the cycle after the request. Unaligned or unmapped addresses read 0, and writes to them change nothing.
- R3: `pin_oe[i]` is 1 exactly when the direction bit is 1 and the role bit is 0. `pin_out` mirrors the output data register.
- R4: The input data register reads the pin levels through a two-flop synchroniser. Writes to it are ignored.
- R5: A level-sensed interrupt pin (role 1, edge select 0) is pending while its synchronised level XOR its sense bit is 1. Sense 0 means active high and sense 1 means active low. The pending state is not latched, and a clear write does not remove it.
- R6: An edge-sensed pin with both-edge 0 latches a flag on a rising edge when its sense bit is 0, and on a falling edge when its sense bit is 1. The flag shows on `irq_out` three clock edges after the pin changes.
- R7: An edge-sensed pin with both-edge 1 latches on either transition, whatever its sense bit.
- R8: Writing 1 to a bit of the clear register drops that pin's edge flag. Bits written as 0 leave their flags unchanged. The pending register reads the flags, and writes to it are ignored.
- R9: Writing 1 to an enable-set bit enables that pin. A write to the enable/disable register disables every pin written as 0 and leaves pins written as 1 unchanged. Both addresses read back the current enables.
- R10: `irq_out` is the OR over all pins of pending AND enabled. A pin whose role bit is 0 never pends.
- R11: The filter control register stores and reads back its value and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Per-pin output enable |
| irq_out | output | 1 | Combined interrupt |

## Verification
Results come due at several distinct delays:
- Register writes land on the edge that accepts them.
- Read data follows one edge after the request.
- A pin change reaches the input data register and level-pending after two edges.
- An edge flag appears after three edges.

The bench drives inputs and samples outputs on falling clock edges. It counts edges from each stimulus before sampling. The timing checks look one edge before each due point, where the result must still be absent, and again at the due point itself. Table-driven vectors wait well past these delays so that only the settled state is compared.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 7;
  localparam int BUS_W  = 32;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ROLE, SEL_DIR, SEL_DOUT, SEL_DIN, SEL_PEND, SEL_CLR,
    SEL_MASK, SEL_UNMASK, SEL_SENSE, SEL_EDGE, SEL_FILT, SEL_BOTH
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a[ADDR_W-1:2])
      5'h00:   s = SEL_ROLE;
      5'h01:   s = SEL_DIR;
      5'h02:   s = SEL_DOUT;
      5'h03:   s = SEL_DIN;
      5'h04:   s = SEL_PEND;
      5'h05:   s = SEL_CLR;
      5'h06:   s = SEL_MASK;
      5'h07:   s = SEL_UNMASK;
      5'h08:   s = SEL_SENSE;
      5'h09:   s = SEL_EDGE;
      5'h0A:   s = SEL_FILT;
      5'h13:   s = SEL_BOTH;
      default: s = SEL_NONE;
    endcase
    if (a[1:0] != 2'b00) s = SEL_NONE;
    return s;
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_i,
  output logic [NPINS-1:0] sync_o
);
  logic [NPINS-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= async_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] role_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] edge_sel_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] prev_q;
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, want;
    assign rise = lvl_i[i] & ~prev_q[i];
    assign fall = ~lvl_i[i] & prev_q[i];
    assign want = both_i[i] ? (rise | fall) : (sense_i[i] ? fall : rise);
    assign hit[i] = role_i[i] & edge_sel_i[i] & want;
    assign pend_o[i] = role_i[i] &
                       (edge_sel_i[i] ? flag_q[i] : (lvl_i[i] ^ sense_i[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= (flag_q & ~clr_i) | hit;
    end
  end

  // R6: a flag never rises without a detected transition
  a_r6_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0));
  // R8: a clear with no concurrent event leaves the flag low
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(clr_i & ~hit)) == '0));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic [NPINS-1:0]  din_i,
  input  logic [NPINS-1:0]  pend_i,
  output logic [NPINS-1:0]  role_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  sense_o,
  output logic [NPINS-1:0]  edge_sel_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata
);
  reg_sel_e         sel;
  logic             wr_en, rd_en;
  logic [NPINS-1:0] wd, filt_q, rd_word;
  logic [BUS_W-1:0] rd_ext;

  assign sel   = decode_addr(req_addr);
  assign wr_en = req_valid & req_write;
  assign rd_en = req_valid & ~req_write;
  assign wd    = req_wdata[NPINS-1:0];
  assign clr_o = (wr_en && sel == SEL_CLR) ? wd : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      role_o <= '0; dir_o <= '0; dout_o <= '0; sense_o <= '0;
      edge_sel_o <= '0; both_o <= '0; mask_o <= '0; filt_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_ROLE:   role_o     <= wd;
        SEL_DIR:    dir_o      <= wd;
        SEL_DOUT:   dout_o     <= wd;
        SEL_SENSE:  sense_o    <= wd;
        SEL_EDGE:   edge_sel_o <= wd;
        SEL_BOTH:   both_o     <= wd;
        SEL_FILT:   filt_q     <= wd;
        SEL_MASK:   mask_o     <= mask_o & wd;
        SEL_UNMASK: mask_o     <= mask_o | wd;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ROLE:   rd_word = role_o;
      SEL_DIR:    rd_word = dir_o;
      SEL_DOUT:   rd_word = dout_o;
      SEL_DIN:    rd_word = din_i;
      SEL_PEND:   rd_word = pend_i;
      SEL_MASK:   rd_word = mask_o;
      SEL_UNMASK: rd_word = mask_o;
      SEL_SENSE:  rd_word = sense_o;
      SEL_EDGE:   rd_word = edge_sel_o;
      SEL_FILT:   rd_word = filt_q;
      SEL_BOTH:   rd_word = both_o;
      default:    rd_word = '0;
    endcase
    rd_ext = '0;
    rd_ext[NPINS-1:0] = rd_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_en;
      rsp_rdata <= rd_en ? rd_ext : '0;
    end
  end

  // R9: enable-set writes turn on every bit written as 1
  a_r9_unmask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_UNMASK) |=> ((mask_o & $past(wd)) == $past(wd)));
  // R9: a write to the enable/disable register never enables a pin
  a_r9_mask_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_MASK) |=> ((mask_o & ~$past(mask_o)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_out
);
  logic [NPINS-1:0] lvl, pend, role, dir, dout, sense, edge_sel, both, mask, clr;

  gpio_bank_sync #(.NPINS(NPINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(lvl)
  );

  gpio_bank_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .din_i(lvl), .pend_i(pend),
    .role_o(role), .dir_o(dir), .dout_o(dout), .sense_o(sense),
    .edge_sel_o(edge_sel), .both_o(both), .mask_o(mask), .clr_o(clr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  gpio_bank_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .role_i(role), .sense_i(sense),
    .edge_sel_i(edge_sel), .both_i(both), .clr_i(clr), .pend_o(pend)
  );

  assign pin_out = dout;
  assign pin_oe  = dir & ~role;
  assign irq_out = |(pend & mask);

  // R10: the interrupt line needs at least one enabled pin
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (mask != '0));
  // R10: the interrupt line needs at least one pending pin
  a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend != '0));
endmodule

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPINS(32)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_out(irq_out)
  );

  localparam logic [6:0] A_ROLE = 7'h00, A_DIR = 7'h04, A_DOUT = 7'h08,
    A_DIN = 7'h0C, A_PEND = 7'h10, A_CLR = 7'h14, A_MASK = 7'h18,
    A_UNMASK = 7'h1C, A_SENSE = 7'h20, A_EDGE = 7'h24, A_FILT = 7'h28,
    A_BOTH = 7'h4C;

  typedef struct packed {
    logic [31:0] role, edg, sense, both, a, b, msk, exp;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'hFFFFFFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0F0F0F0F, 32'h0, 32'h0F0F0F0F, 1'b0},
    '{32'hFFFFFFFF, 32'h0, 32'hFFFF0000, 32'h0, 32'h0, 32'h00FF00FF, 32'h1, 32'hFF0000FF, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0000FFFF, 32'h00FF00FF, 32'h0000FFFF, 32'h00FF0000, 1'b0},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0000FFFF, 32'h00FF00FF, 32'hFFFFFFFF, 32'h0000FF00, 1'b1},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF00FF, 32'hFFFFFFFF, 32'h00FFFF00, 1'b1},
    '{32'h0000FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 1'b1},
    '{32'hFFFFFFFF, 32'h00FF00FF, 32'h0, 32'h0, 32'h00000F0F, 32'h0F0F0F0F, 32'hFFFF0000, 32'h0F0F0F00, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (rsp_valid !== 1'b1) begin
      checks++; errors++;
      $display("FAIL R2 rsp_valid actual %0b expected 1", rsp_valid);
    end
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);
    rd(A_ROLE, d);  check("R1 role", d, 32'h0);
    rd(A_MASK, d);  check("R1 mask", d, 32'h0);
    rd(A_PEND, d);  check("R1 pending", d, 32'h0);

    // table-driven interrupt vectors: R5 R6 R7 R10
    for (int v = 0; v < 7; v++) begin
      wr(A_ROLE, VECS[v].role);
      wr(A_EDGE, VECS[v].edg);
      wr(A_SENSE, VECS[v].sense);
      wr(A_BOTH, VECS[v].both);
      wr(A_MASK, 32'h0);
      wr(A_UNMASK, VECS[v].msk);
      pin_in = VECS[v].a;
      idle(5);
      wr(A_CLR, 32'hFFFFFFFF);
      pin_in = VECS[v].b;
      idle(5);
      rd(A_PEND, d);
      check($sformatf("R5,R6,R7 pending vector %0d", v), d, VECS[v].exp);
      rd(A_UNMASK, d);
      check($sformatf("R9 mask readback vector %0d", v), d, VECS[v].msk);
      check($sformatf("R10 irq vector %0d", v), {31'h0, irq_out}, {31'h0, VECS[v].irq});
    end

    // R3 direction and role override
    wr(A_ROLE, 32'h0);
    wr(A_DIR, 32'hFFFF0000);
    wr(A_DOUT, 32'hA5A5A5A5);
    check("R3 pin_out", pin_out, 32'hA5A5A5A5);
    check("R3 pin_oe", pin_oe, 32'hFFFF0000);
    wr(A_ROLE, 32'h0F000000);
    check("R3 pin_oe with irq role", pin_oe, 32'hF0FF0000);

    // R4 synchronised input, writes ignored
    wr(A_ROLE, 32'h0);
    pin_in = 32'h12345678;
    idle(3);
    wr(A_DIN, 32'hFFFFFFFF);
    rd(A_DIN, d); check("R4 input data", d, 32'h12345678);

    // R2 unmapped/unaligned, R11 filter storage
    rd(7'h30, d); check("R2 unmapped read", d, 32'h0);
    wr(7'h29, 32'hFFFFFFFF);
    rd(A_FILT, d); check("R2 unaligned write ignored", d, 32'h0);
    wr(A_FILT, 32'h00C0FFEE);
    rd(A_FILT, d); check("R11 filter readback", d, 32'h00C0FFEE);
    check("R11 no pin effect", pin_oe, 32'hFFFF0000);

    // R8 write-one-to-clear on edge flags
    pin_in = 32'h0;
    wr(A_EDGE, 32'hFFFFFFFF); wr(A_SENSE, 32'h0); wr(A_BOTH, 32'h0);
    wr(A_ROLE, 32'hFFFFFFFF);
    idle(4);
    wr(A_CLR, 32'hFFFFFFFF);
    pin_in = 32'h000000FF;
    idle(4);
    wr(A_PEND, 32'h0);
    rd(A_PEND, d); check("R8 pending write ignored", d, 32'h000000FF);
    wr(A_CLR, 32'h0);
    rd(A_PEND, d); check("R8 zero clear no effect", d, 32'h000000FF);
    wr(A_CLR, 32'h00000004);
    rd(A_PEND, d); check("R8 single clear", d, 32'h000000FB);

    // R9 masking by zero bits
    wr(A_UNMASK, 32'hFFFFFFFF);
    wr(A_MASK, 32'hFFFFFFFE);
    rd(A_MASK, d); check("R9 disable bit0", d, 32'hFFFFFFFE);
    wr(A_MASK, 32'h00000008);
    rd(A_MASK, d); check("R9 keep bit3 only", d, 32'h00000008);
    check("R10 irq from pin3", {31'h0, irq_out}, 32'h1);
    wr(A_CLR, 32'h00000008);
    check("R10 irq after clear", {31'h0, irq_out}, 32'h0);

    // R6 latency: rising edge on pin 8 shows on third edge
    wr(A_UNMASK, 32'h00000100);
    @(negedge clk); pin_in = 32'h000001FF;
    @(negedge clk);
    @(negedge clk); check("R6 no irq after two edges", {31'h0, irq_out}, 32'h0);
    @(negedge clk); check("R6 irq after three edges", {31'h0, irq_out}, 32'h1);

    // R5 level latency and clear immunity: pin 9 active low
    wr(A_MASK, 32'h0);
    wr(A_EDGE, 32'h0);
    wr(A_SENSE, 32'h00000200);
    pin_in = 32'h00000200;
    wr(A_UNMASK, 32'h00000200);
    idle(3);
    check("R5 inactive level", {31'h0, irq_out}, 32'h0);
    @(negedge clk); pin_in = 32'h0;
    @(negedge clk); check("R5 not yet after one edge", {31'h0, irq_out}, 32'h0);
    @(negedge clk); check("R5 level after two edges", {31'h0, irq_out}, 32'h1);
    wr(A_CLR, 32'hFFFFFFFF);
    check("R5 clear has no effect", {31'h0, irq_out}, 32'h1);
    pin_in = 32'h00000200;
    idle(3);
    check("R5 not latched", {31'h0, irq_out}, 32'h0);

    finish_run();
  end
endmodule